// File: doc/BRIEF.md
# Commit-Time Load Replay Checker

This block sits at the last pipeline stage before retirement. It re-executes every committing memory operation in program order. Its results must match what a strictly sequential run of the program would produce. Operations arrive in groups of up to two lanes, and lane 0 is always the older one. Each lane carries:

- a kind (load or store),
- a word address,
- a payload, which is the store data for a store and, for a load, the value the out-of-order core obtained speculatively,
- a sequence tag.

Replayed stores land only in a private verification cache of 8 fully associative word entries and never reach architectural memory. A replayed load looks in that cache first. On a miss it reads the top of the cache hierarchy through a read-only request/response port, which takes no forwarding from any write buffer. The block compares the replayed value with the speculative one. On agreement it signals that the operation may retire. On a difference it raises an ordering violation together with a flush request, reports the tag of the first mismatching load, and drops every younger operation of the group.

The group input is a valid/ready stream. A group is taken on a clock edge where `grp_valid` and `grp_ready` are both high. `grp_ready` stays low until every lane of the taken group has been retired or discarded, so the producer must hold the next group until then. The memory request is also valid/ready. `mem_req_valid` and `mem_req_addr` stay put until `mem_req_ready` is seen. The response carries no handshake and is accepted whenever a read is outstanding.

Top module: `lrc_replay_checker`

## Requirements
- R1: Within a group, lane 1 never retires before lane 0. Each retire pulse on `ret_valid[l]` carries that lane's own tag on `ret_tag[l]`. A lane whose `grp_en[l]` bit is 0 is never retired.
- R2: A store lane (`grp_store[l]`=1) never causes a memory-port request. The block has no path that writes memory.
- R3: A load that finds its address in the verification cache completes with no memory request. A load that misses issues exactly one read at its own address and completes in the cycle `mem_rsp_valid` returns.
- R4: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged.
- R5: A replayed load whose value differs from its payload pulses `viol_valid` and `flush_req` together for one cycle. `viol_tag` equals the tag of the oldest mismatching lane, and that lane does not retire.
- R6: After a violation, any younger lane of the same group is neither retired nor written into the verification cache. The block returns to idle in the next cycle.
- R7: Two enabled lanes complete in one cycle when all of these hold:
  - their addresses differ,
  - at most one of them is a store,
  - neither needs a memory read.
  In every other case lane 0 is finished first. In particular, a load to the same address as an older store in its group reads that store's data.
- R8: A store to an address already held overwrites that entry in place and allocates nothing. A store to a new address takes the next entry in round-robin order, so the ninth distinct store after a clear evicts the oldest one.
- R9: The whole verification cache is invalidated on a violation. It is also invalidated in any cycle where some lane retires while `store_drained` is high and no store is written that cycle.
- R10: `grp_ready` is high only when no group is in progress. A group with both enable bits clear is consumed without effect.
- R11: After reset, `grp_ready` is 1 and `ret_valid`, `viol_valid`, `flush_req` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | Commit group offered |
| grp_ready | output | 1 | Block idle; group taken on this edge when valid |
| grp_en | input | 2 | Per-lane enable; lane 0 is older |
| grp_store | input | 2 | Per-lane kind: 1 store, 0 load |
| grp_addr | input | 2×AW | Per-lane word address |
| grp_data | input | 2×DW | Store data, or speculative load value |
| grp_tag | input | 2×TW | Per-lane sequence tag |
| store_drained | input | 1 | No replayed store is still outstanding toward memory |
| mem_req_valid | output | 1 | Miss read requested |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | AW | Read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DW | Read data |
| ret_valid | output | 2 | Per-lane permission to retire (one-cycle pulse) |
| ret_tag | output | 2×TW | Tags of the retiring lanes |
| viol_valid | output | 1 | Ordering violation detected |
| viol_tag | output | TW | Tag of the first mismatching load |
| flush_req | output | 1 | Pipeline flush request |

## Verification
Dual-lane completion and violation detection can fall in the same cycle. The bench provokes this with a group of two cache-hit loads at distinct addresses. In one case the older load carries a wrong speculative value. It then checks that nothing retires, that the reported tag is lane 0's, and that the single busy cycle still holds. A second group puts a store in lane 1 behind a mismatching lane-0 load. A later load of that store's address must then go to memory. A further group hits the cache, retires and sees `store_drained` in one cycle. The bench judges the invalidation by the memory read that follows.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } lrc_state_e;
endpackage

// File: rtl/lrc_verif_cache.sv
module lrc_verif_cache #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int ENTRIES = 8,
  parameter int PORTS   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [PORTS-1:0][AW-1:0]   rd_addr,
  output logic [PORTS-1:0]           rd_hit,
  output logic [PORTS-1:0][DW-1:0]   rd_data
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0]         vld;
  logic [ENTRIES-1:0][AW-1:0] ent_addr;
  logic [ENTRIES-1:0][DW-1:0] ent_data;
  logic [IW-1:0]              alloc_ptr;

  logic [IW-1:0] wr_idx;
  logic          wr_hit;

  // Store lookup: a hit rewrites in place, a miss takes the round-robin slot.
  always_comb begin
    wr_hit = 1'b0;
    wr_idx = alloc_ptr;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i] && ent_addr[i] == wr_addr) begin
        wr_hit = 1'b1;
        wr_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= '0;
      ent_addr  <= '0;
      ent_data  <= '0;
      alloc_ptr <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx]      <= 1'b1;
      ent_addr[wr_idx] <= wr_addr;
      ent_data[wr_idx] <= wr_data;
      if (!wr_hit) alloc_ptr <= (alloc_ptr == LAST) ? '0 : alloc_ptr + 1'b1;
    end
  end

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_rd
      logic [ENTRIES-1:0] match;
      logic [DW-1:0]      sel;
      always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
          match[i] = vld[i] && (ent_addr[i] == rd_addr[p]);
          if (match[i]) sel = sel | ent_data[i];
        end
      end
      assign rd_hit[p]  = |match;
      assign rd_data[p] = sel;

      // R8: entries never alias, so at most one matches any address
      a_r8_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    end
  endgenerate

  // R9: a clear leaves no valid entry behind
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld == '0));

  // R8: a store hit never moves the allocation pointer
  a_r8_hit_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && !clr) |=> $stable(alloc_ptr));
endmodule

// File: rtl/lrc_replay_sched.sv
module lrc_replay_sched
  import lrc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  lrc_state_e                 state,
  input  logic [LANES-1:0]           pend,
  input  logic [LANES-1:0]           is_store,
  input  logic [LANES-1:0][AW-1:0]   addr,
  input  logic [LANES-1:0][DW-1:0]   payload,
  input  logic [LANES-1:0]           hit,
  input  logic [LANES-1:0][DW-1:0]   hit_data,
  input  logic                       rsp_valid,
  input  logic [DW-1:0]              rsp_data,
  output logic [LANES-1:0]           done,
  output logic [LANES-1:0]           mis,
  output logic                       req_valid,
  output logic [AW-1:0]              req_addr,
  output logic                       wr_en,
  output logic [AW-1:0]              wr_addr,
  output logic [DW-1:0]              wr_data
);
  logic          cur;
  logic          run, waiting;
  logic [DW-1:0] cur_val;
  logic          cur_done, cur_mis;
  logic          dual, sec_done, sec_mis;

  always_comb begin
    cur     = ~pend[0];                 // oldest pending lane
    run     = (state == ST_RUN);
    waiting = (state == ST_WAIT);
    cur_val = waiting ? rsp_data : hit_data[cur];

    cur_done = pend[cur] &
               ((run & (is_store[cur] | hit[cur])) | (waiting & rsp_valid));
    cur_mis  = cur_done & ~is_store[cur] & (cur_val != payload[cur]);

    // Both lanes in one cycle: distinct words, one store at most, no reads.
    dual = run & (pend == 2'b11) & (addr[0] != addr[1]) &
           ~(is_store[0] & is_store[1]) &
           (is_store[0] | hit[0]) & (is_store[1] | hit[1]);
    sec_done = dual & ~cur_mis;
    sec_mis  = sec_done & ~is_store[1] & (hit_data[1] != payload[1]);

    done      = '0;
    mis       = '0;
    done[cur] = cur_done;
    mis[cur]  = cur_mis;
    if (dual) begin
      done[1] = sec_done;
      mis[1]  = sec_mis;
    end

    req_valid = run & pend[cur] & ~is_store[cur] & ~hit[cur];
    req_addr  = addr[cur];

    wr_en   = 1'b0;
    wr_addr = addr[cur];
    wr_data = payload[cur];
    if (cur_done & is_store[cur]) begin
      wr_en = 1'b1;
    end else if (sec_done & is_store[1]) begin
      wr_en   = 1'b1;
      wr_addr = addr[1];
      wr_data = payload[1];
    end
  end
endmodule

// File: rtl/lrc_replay_checker.sv
module lrc_replay_checker
  import lrc_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int TW         = 4,
  parameter int VC_ENTRIES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      grp_valid,
  output logic                      grp_ready,
  input  logic [1:0]                grp_en,
  input  logic [1:0]                grp_store,
  input  logic [1:0][AW-1:0]        grp_addr,
  input  logic [1:0][DW-1:0]        grp_data,
  input  logic [1:0][TW-1:0]        grp_tag,
  input  logic                      store_drained,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [AW-1:0]             mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [DW-1:0]             mem_rsp_data,
  output logic [1:0]                ret_valid,
  output logic [1:0][TW-1:0]        ret_tag,
  output logic                      viol_valid,
  output logic [TW-1:0]             viol_tag,
  output logic                      flush_req
);
  lrc_state_e              state_q;
  logic [LANES-1:0]        pend_q;
  logic [LANES-1:0]        store_q;
  logic [LANES-1:0][AW-1:0] addr_q;
  logic [LANES-1:0][DW-1:0] data_q;
  logic [LANES-1:0][TW-1:0] tag_q;

  logic [LANES-1:0]         vc_hit;
  logic [LANES-1:0][DW-1:0] vc_data;
  logic [LANES-1:0]         done, mis;
  logic                     req_valid;
  logic [AW-1:0]            req_addr;
  logic                     wr_en;
  logic [AW-1:0]            wr_addr;
  logic [DW-1:0]            wr_data;
  logic                     vc_clr;
  logic [LANES-1:0]         pend_left;

  lrc_verif_cache #(.AW(AW), .DW(DW), .ENTRIES(VC_ENTRIES), .PORTS(LANES)) u_vc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (vc_clr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr_q),
    .rd_hit  (vc_hit),
    .rd_data (vc_data)
  );

  lrc_replay_sched #(.AW(AW), .DW(DW)) u_sched (
    .state     (state_q),
    .pend      (pend_q),
    .is_store  (store_q),
    .addr      (addr_q),
    .payload   (data_q),
    .hit       (vc_hit),
    .hit_data  (vc_data),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .done      (done),
    .mis       (mis),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  assign grp_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = req_valid;
  assign mem_req_addr  = req_addr;
  assign ret_valid     = done & ~mis;
  assign ret_tag       = tag_q;
  assign viol_valid    = |mis;
  assign viol_tag      = mis[0] ? tag_q[0] : tag_q[1];
  assign flush_req     = |mis;
  assign vc_clr        = (|mis) | ((|ret_valid) & store_drained & ~wr_en);
  assign pend_left     = pend_q & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      store_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      tag_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (grp_valid && (|grp_en)) begin
            pend_q  <= grp_en;
            store_q <= grp_store;
            addr_q  <= grp_addr;
            data_q  <= grp_data;
            tag_q   <= grp_tag;
            state_q <= ST_RUN;
          end
        end
        default: begin
          if (|mis) begin
            pend_q  <= '0;            // younger lanes are dropped
            state_q <= ST_IDLE;
          end else begin
            pend_q <= pend_left;
            if (pend_left == '0)                     state_q <= ST_IDLE;
            else if (req_valid && mem_req_ready)     state_q <= ST_WAIT;
            else if (state_q == ST_WAIT && (|done))  state_q <= ST_RUN;
          end
        end
      endcase
    end
  end

  // R4: a pending read holds its request until accepted
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2: the lane asking memory is never a store
  a_r2_no_store_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !store_q[~pend_q[0]]);

  // R3: no second read while one is outstanding
  a_r3_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !mem_req_valid);

  // R1: lane 1 never retires while lane 0 is still pending
  a_r1_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid[1] && pend_q[0]) |-> ret_valid[0]);

  // R6: a violation leaves the block idle on the next cycle
  a_r6_idle_after_viol: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |=> grp_ready);

  // R6: a lane-0 violation retires nothing
  a_r6_no_younger_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && mis[0]) |-> (ret_valid == 2'b00));

  // R7: a double retire only happens on distinct words
  a_r7_dual_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid == 2'b11) |-> (addr_q[0] != addr_q[1]));

  // R10: an idle block produces no result
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    grp_ready |-> (ret_valid == 2'b00 && !viol_valid && !mem_req_valid));
endmodule

// File: tb/tb_lrc_replay_checker.sv
module tb_lrc_replay_checker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 16, TW = 4;
  localparam int NV = 14;

  logic clk, rst_n;
  logic grp_valid, grp_ready;
  logic [1:0] grp_en, grp_store;
  logic [1:0][AW-1:0] grp_addr;
  logic [1:0][DW-1:0] grp_data;
  logic [1:0][TW-1:0] grp_tag;
  logic store_drained;
  logic mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic [1:0] ret_valid;
  logic [1:0][TW-1:0] ret_tag;
  logic viol_valid, flush_req;
  logic [TW-1:0] viol_tag;
  logic mem_ready;

  lrc_replay_checker #(.AW(AW), .DW(DW), .TW(TW), .VC_ENTRIES(8)) dut (
    .clk(clk), .rst_n(rst_n),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_en(grp_en),
    .grp_store(grp_store), .grp_addr(grp_addr), .grp_data(grp_data),
    .grp_tag(grp_tag), .store_drained(store_drained),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .viol_valid(viol_valid), .viol_tag(viol_tag), .flush_req(flush_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: word at address a reads {a, ~a}; one-cycle response.
  assign mem_req_ready = mem_ready;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_ready;
      mem_rsp_data  <= {mem_req_addr, ~mem_req_addr};
    end
  end

  typedef struct packed {
    logic [1:0]  en;
    logic [1:0]  st;
    logic [7:0]  a0;
    logic [7:0]  a1;
    logic [15:0] d0;
    logic [15:0] d1;
    logic [1:0]  eret;
    logic        eviol;
    logic        evlane;
    logic [2:0]  ereads;
    logic [2:0]  ecyc;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'b01, 2'b00, 8'd10, 8'd0,  16'h0AF5, 16'h0000, 2'b01, 1'b0, 1'b0, 3'd1, 3'd2},
    '{2'b11, 2'b01, 8'd20, 8'd30, 16'hAAAA, 16'h1EE1, 2'b11, 1'b0, 1'b0, 3'd1, 3'd3},
    '{2'b11, 2'b00, 8'd20, 8'd10, 16'hAAAA, 16'h0AF5, 2'b11, 1'b0, 1'b0, 3'd1, 3'd3},
    '{2'b11, 2'b01, 8'd40, 8'd40, 16'h1111, 16'h1111, 2'b11, 1'b0, 1'b0, 3'd0, 3'd2},
    '{2'b11, 2'b00, 8'd20, 8'd40, 16'hAAAA, 16'h1111, 2'b11, 1'b0, 1'b0, 3'd0, 3'd1},
    '{2'b11, 2'b01, 8'd50, 8'd20, 16'h2222, 16'hAAAA, 2'b11, 1'b0, 1'b0, 3'd0, 3'd1},
    '{2'b11, 2'b00, 8'd50, 8'd20, 16'h2223, 16'hAAAA, 2'b00, 1'b1, 1'b0, 3'd0, 3'd1},
    '{2'b01, 2'b00, 8'd20, 8'd0,  16'h14EB, 16'h0000, 2'b01, 1'b0, 1'b0, 3'd1, 3'd2},
    '{2'b11, 2'b00, 8'd10, 8'd60, 16'h0AF5, 16'h0000, 2'b01, 1'b1, 1'b1, 3'd2, 3'd4},
    '{2'b11, 2'b10, 8'd10, 8'd70, 16'h0000, 16'h3333, 2'b00, 1'b1, 1'b0, 3'd1, 3'd2},
    '{2'b01, 2'b00, 8'd70, 8'd0,  16'h46B9, 16'h0000, 2'b01, 1'b0, 1'b0, 3'd1, 3'd2},
    '{2'b11, 2'b11, 8'd80, 8'd90, 16'h0001, 16'h0002, 2'b11, 1'b0, 1'b0, 3'd0, 3'd2},
    '{2'b11, 2'b00, 8'd80, 8'd90, 16'h0001, 16'h0002, 2'b11, 1'b0, 1'b0, 3'd0, 3'd1},
    '{2'b10, 2'b00, 8'd0,  8'd80, 16'h0000, 16'h0001, 2'b10, 1'b0, 1'b0, 3'd0, 3'd1}
  };

  int checks = 0, errors = 0;
  int o_reads, o_cyc, tag_bad;
  logic [1:0] o_ret;
  logic o_viol;
  logic [TW-1:0] o_vtag;
  logic [TW-1:0] cur_t0, cur_t1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] en, input logic [1:0] st,
                      input logic [7:0] a0, input logic [7:0] a1,
                      input logic [15:0] d0, input logic [15:0] d1,
                      input logic [TW-1:0] t0, input logic [TW-1:0] t1,
                      input logic drn);
    @(negedge clk);
    grp_valid = 1'b1; grp_en = en; grp_store = st;
    grp_addr[0] = a0; grp_addr[1] = a1;
    grp_data[0] = d0; grp_data[1] = d1;
    grp_tag[0] = t0;  grp_tag[1] = t1;
    cur_t0 = t0; cur_t1 = t1;
    store_drained = drn;
    @(negedge clk);
    grp_valid = 1'b0; grp_en = 2'b00;
  endtask

  task automatic collect();
    o_reads = 0; o_cyc = 0; tag_bad = 0; o_ret = 2'b00; o_viol = 1'b0; o_vtag = '0;
    while (!grp_ready && o_cyc < 40) begin
      if (ret_valid[0]) begin o_ret[0] = 1'b1; if (ret_tag[0] != cur_t0) tag_bad++; end
      if (ret_valid[1]) begin o_ret[1] = 1'b1; if (ret_tag[1] != cur_t1) tag_bad++; end
      if (viol_valid) begin o_viol = 1'b1; o_vtag = viol_tag; if (!flush_req) tag_bad++; end
      if (mem_req_valid && mem_req_ready) o_reads++;
      o_cyc++;
      @(negedge clk);
    end
    store_drained = 1'b0;
  endtask

  task automatic run_one(input logic [1:0] st, input logic [7:0] a, input logic [15:0] d,
                         input logic drn);
    send(2'b01, st, a, 8'd0, d, 16'h0, 4'hE, 4'hF, drn);
    collect();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; grp_valid = 1'b0; grp_en = 2'b00; grp_store = 2'b00;
    grp_addr = '0; grp_data = '0; grp_tag = '0; store_drained = 1'b0;
    mem_ready = 1'b1; cur_t0 = '0; cur_t1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(grp_ready == 1'b1, "R11 grp_ready after reset", grp_ready, 1);
    chk(ret_valid == 2'b00, "R11 ret_valid after reset", ret_valid, 0);
    chk(viol_valid == 1'b0 && flush_req == 1'b0, "R11 viol/flush after reset", viol_valid, 0);
    chk(mem_req_valid == 1'b0, "R11 mem_req_valid after reset", mem_req_valid, 0);

    // R10: an empty group is consumed with no effect
    send(2'b00, 2'b00, 8'd1, 8'd2, 16'h0, 16'h0, 4'h0, 4'h0, 1'b0);
    chk(grp_ready == 1'b1 && ret_valid == 2'b00, "R10 empty group", grp_ready, 1);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].en, VECS[i].st, VECS[i].a0, VECS[i].a1, VECS[i].d0, VECS[i].d1,
           TW'(2*i), TW'(2*i+1), 1'b0);
      collect();
      chk(o_ret == VECS[i].eret, $sformatf("R1 R6 vec%0d retire mask", i), o_ret, VECS[i].eret);
      chk(o_viol == VECS[i].eviol, $sformatf("R5 vec%0d violation", i), o_viol, VECS[i].eviol);
      if (VECS[i].eviol)
        chk(o_vtag == (VECS[i].evlane ? TW'(2*i+1) : TW'(2*i)),
            $sformatf("R5 vec%0d violation tag", i), o_vtag,
            VECS[i].evlane ? (2*i+1) % 16 : (2*i) % 16);
      chk(o_reads == int'(VECS[i].ereads), $sformatf("R2 R3 vec%0d memory reads", i),
          o_reads, VECS[i].ereads);
      chk(o_cyc == int'(VECS[i].ecyc), $sformatf("R7 vec%0d busy cycles", i),
          o_cyc, VECS[i].ecyc);
      chk(tag_bad == 0, $sformatf("R1 vec%0d retire tags", i), tag_bad, 0);
    end

    // R8: nine distinct stores evict the oldest entries round-robin
    for (int a = 100; a <= 108; a++) run_one(2'b01, 8'(a), 16'h5000 + 16'(a), 1'b0);
    run_one(2'b00, 8'd100, 16'h649B, 1'b0);
    chk(o_reads == 1 && o_ret == 2'b01, "R8 evicted entry reads memory", o_reads, 1);
    run_one(2'b00, 8'd108, 16'h506C, 1'b0);
    chk(o_reads == 0 && o_ret == 2'b01, "R8 newest entry hits", o_reads, 0);
    run_one(2'b01, 8'd108, 16'hBEEF, 1'b0);
    run_one(2'b00, 8'd101, 16'h5065, 1'b0);
    chk(o_reads == 0 && o_ret == 2'b01, "R8 store hit allocates nothing", o_reads, 0);
    run_one(2'b00, 8'd108, 16'hBEEF, 1'b0);
    chk(o_reads == 0 && o_ret == 2'b01, "R8 store hit overwrites", o_reads, 0);

    // R9: retire with store_drained clears the cache
    run_one(2'b00, 8'd103, 16'h5067, 1'b1);
    chk(o_reads == 0 && o_ret == 2'b01, "R9 hit before drain clear", o_reads, 0);
    run_one(2'b00, 8'd103, 16'h6798, 1'b0);
    chk(o_reads == 1 && o_ret == 2'b01, "R9 drained clear forces miss", o_reads, 1);

    // R4: request held under back-pressure
    mem_ready = 1'b0;
    send(2'b01, 2'b00, 8'd10, 8'd0, 16'h0AF5, 16'h0, 4'h5, 4'h6, 1'b0);
    repeat (3) @(negedge clk);
    chk(mem_req_valid == 1'b1, "R4 request held", mem_req_valid, 1);
    chk(mem_req_addr == 8'd10, "R4 address held", mem_req_addr, 10);
    chk(grp_ready == 1'b0, "R10 busy while stalled", grp_ready, 0);
    mem_ready = 1'b1;
    collect();
    chk(o_ret == 2'b01 && !o_viol, "R4 completes after release", o_ret, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule